// File: doc/BRIEF.md
# Three-Address Memory-to-Memory Instruction Sequencer

This block steps a small teaching machine through its program. Every 32-bit instruction carries an 8-bit opcode and three 8-bit memory addresses. Two of the addresses name source words and the third names a destination or a jump target. For each instruction the sequencer does the following in order: it fetches the word at the program counter, decodes the opcode, reads the operands, hands the work to an external arithmetic unit, and writes the result back to memory.

The memory port has a combinational read: read data must follow the address within the same cycle. Writes happen on a clock edge. The arithmetic unit gets the opcode and both operands, and it holds a request/done handshake. When done is high it returns a low result word, a high result word (the remainder for division) and three compare flags. A conditional jump asks that unit for a subtraction and uses the flags to pick between the jump target and the next instruction. The machine reports one of three states: running, halted, or stopped on an illegal opcode.

Top module: `tri_addr_seq`

## Requirements
- R1: While reset is asserted, `status` is 00 (running), `pc_o` is 0, and neither `mem_we` nor `alu_req` is high. The status code 11 never appears.
- R2: Every instruction fetch advances the program counter by one word. This includes a halt, so a halt fetched at address 0 leaves `pc_o` at 1.
- R3: Opcodes 0x01 add, 0x02 sub, 0x03 signed multiply and 0x13 unsigned multiply each do the same steps. The sequencer reads [A1] and [A2], where A1 is instruction bits 23:16 and A2 is bits 15:8. It presents the opcode and both words to the arithmetic unit, then writes the low result word to [A3], where A3 is bits 7:0. The instruction makes exactly one memory write.
- R4: Move (0x00) copies [A1] into [A3] with one write and never raises `alu_req`.
- R5: Divide opcodes 0x04 (signed) and 0x14 (unsigned) write the quotient to [A3] and the remainder to [A3+1]. The second address wraps modulo 256, so A3 = 0xFF puts the remainder at address 0x00.
- R6: Opcode 0x80 loads the program counter from A3. It writes no memory and raises no ALU request.
- R7: A conditional jump requests opcode 0x02 (subtract) on [A1] and [A2] and then tests the returned flags: bit 0 equal, bit 1 signed less, bit 2 unsigned less. The conditions are 0x81 equal and 0x82 not equal; 0x83/0x93 less, 0x84/0x94 greater-or-equal, 0x85/0x95 less-or-equal and 0x86/0x96 greater, where the 0x8x codes are signed and the 0x9x codes are unsigned. If the condition holds, the program counter becomes A3; otherwise execution continues with the next word. Nothing is written.
- R8: Opcode 0x99 sets `status` to 01. From then on `status`, `pc_o`, memory and the ALU request stay quiet until reset.
- R9: Any opcode outside the map sets `status` to 10, distinct from a normal halt. It writes nothing, and after it `status`, `pc_o`, memory and the ALU request stay quiet.
- R10: `alu_req` stays high until `alu_done` is seen. It drops in the cycle after done. No memory write occurs while a request is pending.
- R11: The following program leaves 22 in [4], `pc_o` at 6 and `status` halted: [0] = add [2],[3] into [4]; [1] = jneq [2],[3] to 5; [5] = halt; with [2] = 12 and [3] = 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | ADDR_W | Word address for read or write |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Combinational read data for `mem_addr` |
| alu_req | output | 1 | Operation request, held until done |
| alu_op | output | 8 | Operation code for the ALU |
| alu_a | output | DATA_W | First operand |
| alu_b | output | DATA_W | Second operand |
| alu_done | input | 1 | ALU result valid |
| alu_lo | input | DATA_W | Result / quotient |
| alu_hi | input | DATA_W | Remainder |
| alu_flags | input | 3 | Compare flags: equal, signed less, unsigned less |
| status | output | 2 | 00 running, 01 halted, 10 illegal opcode |
| pc_o | output | ADDR_W | Program counter |

## Verification
Each instruction costs a fixed number of cycles: one each for fetch, decode and each operand read, then the ALU wait, then one write cycle per result word. The memory and program counter effects are therefore settled by the time `status` leaves running on the final halt. The bench steps on falling edges until it sees that change, and only then compares memory, `pc_o` and its write and request counters. The bench's ALU raises done on the third falling edge of a request, so each ALU instruction must show exactly three request cycles.

// File: rtl/tas_pkg.sv
`timescale 1ns/1ps
package tas_pkg;

    localparam int unsigned OP_W   = 8;
    localparam int unsigned FLAG_W = 3;
    localparam int unsigned FLAG_EQ  = 0;
    localparam int unsigned FLAG_SLT = 1;
    localparam int unsigned FLAG_ULT = 2;

    localparam logic [OP_W-1:0] OPC_MOVE = 8'h00;
    localparam logic [OP_W-1:0] OPC_ADD  = 8'h01;
    localparam logic [OP_W-1:0] OPC_SUB  = 8'h02;
    localparam logic [OP_W-1:0] OPC_SMUL = 8'h03;
    localparam logic [OP_W-1:0] OPC_SDIV = 8'h04;
    localparam logic [OP_W-1:0] OPC_UMUL = 8'h13;
    localparam logic [OP_W-1:0] OPC_UDIV = 8'h14;
    localparam logic [OP_W-1:0] OPC_JMP  = 8'h80;
    localparam logic [OP_W-1:0] OPC_HALT = 8'h99;

    typedef enum logic [2:0] {
        CLS_MOVE, CLS_ALU, CLS_DIV, CLS_JMP, CLS_CJMP, CLS_HALT, CLS_BAD
    } cls_e;

    typedef enum logic [2:0] {
        C_NONE = 3'd0, C_EQ = 3'd1, C_NE = 3'd2, C_LT = 3'd3,
        C_GE = 3'd4, C_LE = 3'd5, C_GT = 3'd6
    } cond_e;

    typedef struct packed {
        cls_e  cls;
        cond_e cond;
        logic  uns;
    } dec_t;

    typedef enum logic [1:0] {
        ST_RUN = 2'b00, ST_HALT = 2'b01, ST_ERR = 2'b10
    } stat_e;

    typedef enum logic [2:0] {
        PH_FETCH, PH_DECODE, PH_LD1, PH_LD2, PH_EXEC, PH_WB1, PH_WB2, PH_STOP
    } phase_e;

endpackage

// File: rtl/tas_decode.sv
`timescale 1ns/1ps
module tas_decode
    import tas_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output dec_t            dec
);
    always_comb begin
        dec.cls  = CLS_BAD;
        dec.cond = C_NONE;
        dec.uns  = opcode[4];
        case (opcode)
            OPC_MOVE:                             dec.cls = CLS_MOVE;
            OPC_ADD, OPC_SUB, OPC_SMUL, OPC_UMUL: dec.cls = CLS_ALU;
            OPC_SDIV, OPC_UDIV:                   dec.cls = CLS_DIV;
            OPC_JMP:                              dec.cls = CLS_JMP;
            OPC_HALT:                             dec.cls = CLS_HALT;
            8'h81, 8'h82, 8'h83, 8'h84, 8'h85, 8'h86,
            8'h93, 8'h94, 8'h95, 8'h96: begin
                dec.cls  = CLS_CJMP;
                dec.cond = cond_e'(opcode[2:0]);
            end
            default: dec.cls = CLS_BAD;
        endcase
    end
endmodule

// File: rtl/tas_branch.sv
`timescale 1ns/1ps
module tas_branch
    import tas_pkg::*;
(
    input  dec_t              dec,
    input  logic [FLAG_W-1:0] flags,
    output logic              take
);
    logic lt, eq;

    always_comb begin
        lt = dec.uns ? flags[FLAG_ULT] : flags[FLAG_SLT];
        eq = flags[FLAG_EQ];
        case (dec.cond)
            C_EQ:    take = eq;
            C_NE:    take = !eq;
            C_LT:    take = lt;
            C_GE:    take = !lt;
            C_LE:    take = lt | eq;
            C_GT:    take = !lt & !eq;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/tri_addr_seq.sv
`timescale 1ns/1ps
module tri_addr_seq
    import tas_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = OP_W + 3 * ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_we,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 alu_req,
    output logic [OP_W-1:0]      alu_op,
    output logic [DATA_W-1:0]    alu_a,
    output logic [DATA_W-1:0]    alu_b,
    input  logic                 alu_done,
    input  logic [DATA_W-1:0]    alu_lo,
    input  logic [DATA_W-1:0]    alu_hi,
    input  logic [FLAG_W-1:0]    alu_flags,
    output logic [1:0]           status,
    output logic [ADDR_W-1:0]    pc_o
);
    localparam int unsigned A1_HI = 3 * ADDR_W - 1;
    localparam int unsigned A2_HI = 2 * ADDR_W - 1;

    typedef struct packed {
        phase_e              ph;
        stat_e               st;
        logic [ADDR_W-1:0]   pc;
        logic [DATA_W-1:0]   ir;
        logic [DATA_W-1:0]   r1;
        logic [DATA_W-1:0]   r2;
        logic [DATA_W-1:0]   lo;
        logic [DATA_W-1:0]   hi;
    } seq_t;

    seq_t s_d, s_q;
    dec_t dec;
    logic take;

    logic [OP_W-1:0]   opc;
    logic [ADDR_W-1:0] a1, a2, a3, a3_inc;

    assign opc    = s_q.ir[DATA_W-1 -: OP_W];
    assign a1     = s_q.ir[A1_HI -: ADDR_W];
    assign a2     = s_q.ir[A2_HI -: ADDR_W];
    assign a3     = s_q.ir[ADDR_W-1:0];
    assign a3_inc = a3 + ADDR_W'(1);

    tas_decode u_dec (.opcode(opc), .dec(dec));
    tas_branch u_br  (.dec(dec), .flags(alu_flags), .take(take));

    always_comb begin
        mem_addr  = a3;
        mem_we    = 1'b0;
        mem_wdata = s_q.lo;
        case (s_q.ph)
            PH_FETCH: mem_addr = s_q.pc;
            PH_LD1:   mem_addr = a1;
            PH_LD2:   mem_addr = a2;
            PH_WB1:   mem_we   = 1'b1;
            PH_WB2: begin
                mem_addr  = a3_inc;
                mem_we    = 1'b1;
                mem_wdata = s_q.hi;
            end
            default: ;
        endcase
        alu_req = (s_q.ph == PH_EXEC);
        alu_op  = (dec.cls == CLS_CJMP) ? OPC_SUB : opc;
        alu_a   = s_q.r1;
        alu_b   = s_q.r2;
        status  = s_q.st;
        pc_o    = s_q.pc;
    end

    always_comb begin
        s_d = s_q;
        case (s_q.ph)
            PH_FETCH: begin
                s_d.ir = mem_rdata;
                s_d.pc = s_q.pc + ADDR_W'(1);
                s_d.ph = PH_DECODE;
            end
            PH_DECODE: begin
                case (dec.cls)
                    CLS_BAD:  begin s_d.st = ST_ERR;  s_d.ph = PH_STOP; end
                    CLS_HALT: begin s_d.st = ST_HALT; s_d.ph = PH_STOP; end
                    CLS_JMP:  begin s_d.pc = a3;      s_d.ph = PH_FETCH; end
                    default:  s_d.ph = PH_LD1;
                endcase
            end
            PH_LD1: begin
                s_d.r1 = mem_rdata;
                s_d.lo = mem_rdata;
                s_d.ph = (dec.cls == CLS_MOVE) ? PH_WB1 : PH_LD2;
            end
            PH_LD2: begin
                s_d.r2 = mem_rdata;
                s_d.ph = PH_EXEC;
            end
            PH_EXEC: begin
                if (alu_done) begin
                    s_d.lo = alu_lo;
                    s_d.hi = alu_hi;
                    if (dec.cls == CLS_CJMP) begin
                        if (take) s_d.pc = a3;
                        s_d.ph = PH_FETCH;
                    end else begin
                        s_d.ph = PH_WB1;
                    end
                end
            end
            PH_WB1:  s_d.ph = (dec.cls == CLS_DIV) ? PH_WB2 : PH_FETCH;
            PH_WB2:  s_d.ph = PH_FETCH;
            default: s_d.ph = PH_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= PH_FETCH;
            s_q.st <= ST_RUN;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/tri_addr_seq_chk.sv
`timescale 1ns/1ps
module tri_addr_seq_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        status,
    input logic [ADDR_W-1:0] pc_o,
    input logic              mem_we,
    input logic              alu_req,
    input logic              alu_done
);
    // R1
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11);
    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status == 2'b01 |=> status == 2'b01 && $stable(pc_o) && !mem_we && !alu_req);
    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status == 2'b10 |=> status == 2'b10 && $stable(pc_o) && !mem_we && !alu_req);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_req && !alu_done |=> alu_req);
    // R10
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_req && alu_done |=> !alu_req);
    // R10
    no_write_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !alu_req);
endmodule

bind tri_addr_seq tri_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .status(status), .pc_o(pc_o),
    .mem_we(mem_we), .alu_req(alu_req), .alu_done(alu_done)
);

// File: tb/sim_tri_addr_seq.sv
`timescale 1ns/1ps
module sim_tri_addr_seq;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [31:0] HALT_W = 32'h9900_0000;
    localparam logic [31:0] CANARY = 32'hC0FF_EE00;
    localparam int NV = 17;
    // {opcode, a, b, expected low word or taken flag, expected remainder}
    localparam logic [135:0] VEC [NV] = '{
        {8'h01, 32'd12,        32'd10,  32'd22,        32'h0},
        {8'h02, 32'd5,         32'd7,   32'hFFFF_FFFE, 32'h0},
        {8'h03, 32'hFFFF_FFFD, 32'd7,   32'hFFFF_FFEB, 32'h0},
        {8'h13, 32'h0001_0000, 32'h0001_0000, 32'h0,   32'h0},
        {8'h04, 32'hFFFF_FFEB, 32'd5,   32'hFFFF_FFFC, 32'hFFFF_FFFF},
        {8'h14, 32'd100,       32'd7,   32'd14,        32'd2},
        {8'h00, 32'h1234_5678, 32'd9,   32'h1234_5678, 32'h0},
        {8'h81, 32'd4,         32'd4,   32'd1, 32'h0},
        {8'h82, 32'd4,         32'd4,   32'd0, 32'h0},
        {8'h83, 32'hFFFF_FFFF, 32'd1,   32'd1, 32'h0},
        {8'h84, 32'hFFFF_FFFF, 32'd1,   32'd0, 32'h0},
        {8'h85, 32'd3,         32'd3,   32'd1, 32'h0},
        {8'h86, 32'd3,         32'd2,   32'd1, 32'h0},
        {8'h93, 32'hFFFF_FFFF, 32'd1,   32'd0, 32'h0},
        {8'h94, 32'hFFFF_FFFF, 32'd1,   32'd1, 32'h0},
        {8'h95, 32'd2,         32'd3,   32'd1, 32'h0},
        {8'h96, 32'd2,         32'd3,   32'd0, 32'h0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic mem_we;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic alu_req, alu_done;
    logic [7:0] alu_op;
    logic [DW-1:0] alu_a, alu_b, alu_lo, alu_hi;
    logic [2:0] alu_flags;
    logic [1:0] status;
    logic [AW-1:0] pc_o;

    logic [31:0] mem [256];
    int nchk = 0, nfail = 0;
    int wr_count = 0, req_cycles = 0;
    logic [7:0] seen_op;
    logic [1:0] wait_cnt;

    always #10 clk = ~clk;

    tri_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .alu_req(alu_req),
        .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b), .alu_done(alu_done),
        .alu_lo(alu_lo), .alu_hi(alu_hi), .alu_flags(alu_flags),
        .status(status), .pc_o(pc_o)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
    end

    // reference arithmetic unit
    always_comb begin
        alu_lo = '0;
        alu_hi = '0;
        case (alu_op)
            8'h01: alu_lo = alu_a + alu_b;
            8'h02: alu_lo = alu_a - alu_b;
            8'h03: alu_lo = $signed(alu_a) * $signed(alu_b);
            8'h13: alu_lo = alu_a * alu_b;
            8'h04: if (alu_b != 0) begin
                alu_lo = $signed(alu_a) / $signed(alu_b);
                alu_hi = $signed(alu_a) % $signed(alu_b);
            end
            8'h14: if (alu_b != 0) begin
                alu_lo = alu_a / alu_b;
                alu_hi = alu_a % alu_b;
            end
            default: ;
        endcase
        alu_flags = {alu_a < alu_b, $signed(alu_a) < $signed(alu_b), alu_a == alu_b};
    end

    always @(negedge clk) begin
        if (!rst_n || !alu_req) begin
            wait_cnt <= 2'd0;
            alu_done <= 1'b0;
        end else begin
            wait_cnt   <= wait_cnt + 2'd1;
            alu_done   <= (wait_cnt == 2'd2);
            req_cycles <= req_cycles + 1;
            seen_op    <= alu_op;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 256; i++) mem[i] = '0;
        wr_count = 0;
        req_cycles = 0;
        seen_op = '0;
    endtask

    task automatic run_prog();
        int n;
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (status == 2'b00 && n < 500) begin
            @(negedge clk);
            n++;
        end
        if (n >= 500) chk("run timeout", 32'(n), 32'd0);
    endtask

    initial begin
        #3_000_000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        clear_all();
        @(negedge clk);
        // R1 reset state
        chk("R1 status", 32'(status), 32'd0);
        chk("R1 pc", 32'(pc_o), 32'd0);
        chk("R1 we/req", {30'd0, mem_we, alu_req}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            logic [7:0] op;
            logic [31:0] a, b, e0, e1;
            logic jmp, dv, mv;
            {op, a, b, e0, e1} = VEC[v];
            jmp = op[7];
            dv  = (op == 8'h04) || (op == 8'h14);
            mv  = (op == 8'h00);
            clear_all();
            mem[0] = {op, 8'h10, 8'h11, jmp ? 8'h05 : 8'h20};
            mem[1] = HALT_W;
            mem[5] = HALT_W;
            mem[16] = a;
            mem[17] = b;
            mem[33] = CANARY;
            run_prog();
            if (jmp) begin
                // R7
                chk($sformatf("R7 pc op %h", op), 32'(pc_o), e0[0] ? 32'd6 : 32'd2);
                chk($sformatf("R7 writes op %h", op), 32'(wr_count), 32'd0);
                chk($sformatf("R7 alu op for %h", op), 32'(seen_op), 32'h02);
            end else begin
                // R3 R4 R5
                chk($sformatf("R3 result op %h", op), mem[32], e0);
                chk($sformatf("R5 second word op %h", op), mem[33], dv ? e1 : CANARY);
                chk($sformatf("R3 writes op %h", op), 32'(wr_count), dv ? 32'd2 : 32'd1);
                // R2 R8
                chk($sformatf("R2 pc op %h", op), 32'(pc_o), 32'd2);
                chk($sformatf("R8 status op %h", op), 32'(status), 32'd1);
            end
            // R10 and R4: three request cycles per ALU job, none for move
            chk($sformatf("R10 req cycles op %h", op), 32'(req_cycles), mv ? 32'd0 : 32'd3);
        end

        // R2 halt at address 0
        clear_all();
        mem[0] = HALT_W;
        run_prog();
        chk("R2 pc after halt", 32'(pc_o), 32'd1);
        chk("R8 halted", 32'(status), 32'd1);
        repeat (10) @(negedge clk);
        chk("R8 pc stays", 32'(pc_o), 32'd1);
        chk("R8 no writes", 32'(wr_count), 32'd0);

        // R6 unconditional jump
        clear_all();
        mem[0] = 32'h8011_2207;
        mem[7] = HALT_W;
        run_prog();
        chk("R6 pc", 32'(pc_o), 32'd8);
        chk("R6 writes", 32'(wr_count), 32'd0);
        chk("R6 no req", 32'(req_cycles), 32'd0);

        // R9 illegal opcodes
        clear_all();
        mem[0] = 32'h0510_1120;
        mem[16] = 32'd3;
        run_prog();
        chk("R9 status 05", 32'(status), 32'd2);
        chk("R9 pc 05", 32'(pc_o), 32'd1);
        chk("R9 dest untouched", mem[32], 32'd0);
        repeat (8) @(negedge clk);
        chk("R9 no writes", 32'(wr_count), 32'd0);
        chk("R9 no req", 32'(req_cycles), 32'd0);
        clear_all();
        mem[0] = 32'hFF00_0000;
        run_prog();
        chk("R9 status FF", 32'(status), 32'd2);

        // R5 remainder address wraps
        clear_all();
        mem[0] = 32'h1410_11FF;
        mem[1] = HALT_W;
        mem[16] = 32'd100;
        mem[17] = 32'd7;
        run_prog();
        chk("R5 quotient at FF", mem[255], 32'd14);
        chk("R5 remainder at 00", mem[0], 32'd2);

        // R11 sample program
        clear_all();
        mem[0] = 32'h0102_0304;
        mem[1] = 32'h8202_0305;
        mem[2] = 32'd12;
        mem[3] = 32'd10;
        mem[5] = HALT_W;
        run_prog();
        chk("R11 sum", mem[4], 32'd22);
        chk("R11 pc", 32'(pc_o), 32'd6);
        chk("R11 status", 32'(status), 32'd1);

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule